// File: doc/BRIEF.md
# Hi/Lo Iterative Multiply-Divide Unit

This block sits next to an integer datapath and performs 32-bit multiplication and division over several cycles. A start command carries an operation code and two operands. A multiply leaves its 64-bit product split across two result registers, Hi and Lo. A divide leaves the remainder in Hi and the quotient in Lo. Signed and unsigned variants share one shift-add / restoring-division datapath. The signed variants work on magnitudes and fix the signs when they write the result.

A read port serves the move-from-Hi and move-from-Lo requests. A read issued while an operation is still running is held off with a stall signal. Division by zero still completes on the normal schedule and sets a sticky flag.

Top module: `muldiv_unit`

## Requirements
- R1: A start with code 24 (signed multiply), 25 (unsigned multiply), 26 (signed divide) or 27 (unsigned divide) while idle raises busy in the next cycle. Busy stays high for exactly 32 cycles. In the cycle after busy falls, done is high for one cycle, with busy low and the results readable.
- R2: Code 25 treats both operands as unsigned. It leaves bits 63..32 of the product in Hi and bits 31..0 in Lo.
- R3: Code 24 treats both operands as two's complement. It leaves the 64-bit signed product, split the same way, in Hi and Lo.
- R4: Code 27 treats both operands as unsigned. It leaves the quotient in Lo and the remainder in Hi.
- R5: Code 26 divides two's complement operands. The quotient is truncated toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend. Dividing 0x80000000 by -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide by zero, signed or unsigned, completes on the normal schedule with Lo = 0xFFFFFFFF and Hi = the dividend. It sets divZeroFlag, which stays high until reset.
- R7: When not busy, a read with readFn = 16 returns Hi and readFn = 18 returns Lo on readData in the same cycle, and stall stays low.
- R8: A read request in any cycle while busy raises stall in that cycle.
- R9: A start while busy is ignored. The running operation finishes on its original schedule with its original result.
- R10: A start with any code other than 24..27 is ignored. Busy stays low and Hi and Lo keep their values.
- R11: After reset, busy, done, stall and divZeroFlag are low, and Hi and Lo read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startValid | input | 1 | Start command strobe |
| startOp | input | 6 | Operation code (24..27) |
| opA | input | 32 | First operand / dividend |
| opB | input | 32 | Second operand / divisor |
| readValid | input | 1 | Read request |
| readFn | input | 6 | Read select: 16 for Hi, 18 for Lo |
| readData | output | 32 | Selected result register, zero when stalled or unselected |
| stall | output | 1 | Read held off while busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| divZeroFlag | output | 1 | Sticky divide-by-zero indication |

## Verification
The checker watches the control behaviour on every cycle. It checks that a legal idle start raises busy and that an illegal one does not. It counts the busy run in front of each done and requires it to be 32 cycles, and it requires done to last one cycle with busy low. It also checks that a read during busy stalls, that nothing stalls while idle, and that the divide-by-zero flag never drops. The arithmetic itself can only be shown by the bench's scenarios. These compare Hi and Lo against an independent 64-bit model for both signs of multiply and divide, the most-negative quotient overflow case, and division by zero. The scenarios also cover ignored starts, whether mid-run or with an illegal code.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam logic [5:0] OP_MULT  = 6'd24;
  localparam logic [5:0] OP_MULTU = 6'd25;
  localparam logic [5:0] OP_DIV   = 6'd26;
  localparam logic [5:0] OP_DIVU  = 6'd27;
  localparam logic [5:0] RD_HI    = 6'd16;
  localparam logic [5:0] RD_LO    = 6'd18;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands and mode
    logic step;      // run one iteration
    logic finish;    // last iteration: write Hi/Lo
    logic selDiv;    // mode at load: divide
    logic selSigned; // mode at load: two's complement
  } mdStrobe_t;
endpackage

// File: rtl/md_ctrl.sv
module md_ctrl
  import muldiv_pkg::*;
#(
  parameter int ITER = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [5:0] startOp,
  output mdStrobe_t  strobe,
  output logic       busy,
  output logic       done
);
  localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CW-1:0] LAST = CW'(ITER - 1);

  logic [CW-1:0] iterCnt;
  logic legalOp, accept;

  assign legalOp = (startOp == OP_MULT) || (startOp == OP_MULTU) ||
                   (startOp == OP_DIV)  || (startOp == OP_DIVU);
  assign accept  = startValid && !busy && legalOp;

  always_comb begin
    strobe.load      = accept;
    strobe.step      = busy;
    strobe.finish    = busy && (iterCnt == LAST);
    strobe.selDiv    = startOp[1];
    strobe.selSigned = !startOp[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      iterCnt <= '0;
    end else begin
      done <= strobe.finish;
      if (accept) begin
        busy    <= 1'b1;
        iterCnt <= '0;
      end else if (busy) begin
        iterCnt <= iterCnt + 1'b1;
        if (strobe.finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/md_path.sv
module md_path
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] hiReg,
  output logic [W-1:0] loReg,
  output logic         dzFlag
);
  logic [W:0]   accP;
  logic [W-1:0] accQ, divisorM;
  logic         modeDiv, negA, negB, bZero;

  logic [W:0]   mulSum, mulP, shifted, trial, nP;
  logic [W-1:0] nQ;
  logic         fits;
  logic [2*W-1:0] prod;
  logic [W-1:0] quo, rem;
  logic         ldNegA, ldNegB;

  assign ldNegA = strobe.selSigned && opA[W-1];
  assign ldNegB = strobe.selSigned && opB[W-1];

  // one iteration, shift-add or restoring subtract
  always_comb begin
    mulSum  = accP + {1'b0, divisorM};
    mulP    = accQ[0] ? mulSum : accP;
    shifted = {accP[W-1:0], accQ[W-1]};
    trial   = shifted - {1'b0, divisorM};
    fits    = !trial[W];
    if (modeDiv) begin
      nP = fits ? trial : shifted;
      nQ = {accQ[W-2:0], fits};
    end else begin
      nP = {1'b0, mulP[W:1]};
      nQ = {mulP[0], accQ[W-1:1]};
    end
  end

  // sign correction of the final values
  always_comb begin
    prod = {nP[W-1:0], nQ};
    if (negA ^ negB) prod = -prod;
    quo = nQ;
    if (negA ^ negB) quo = -quo;
    if (bZero) quo = '1;
    rem = nP[W-1:0];
    if (negA) rem = -rem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accP     <= '0;
      accQ     <= '0;
      divisorM <= '0;
      modeDiv  <= 1'b0;
      negA     <= 1'b0;
      negB     <= 1'b0;
      bZero    <= 1'b0;
      hiReg    <= '0;
      loReg    <= '0;
      dzFlag   <= 1'b0;
    end else if (strobe.load) begin
      accP     <= '0;
      accQ     <= ldNegA ? -opA : opA;
      divisorM <= ldNegB ? -opB : opB;
      modeDiv  <= strobe.selDiv;
      negA     <= ldNegA;
      negB     <= ldNegB;
      bZero    <= strobe.selDiv && (opB == '0);
    end else if (strobe.step) begin
      accP <= nP;
      accQ <= nQ;
      if (strobe.finish) begin
        if (modeDiv) begin
          hiReg <= rem;
          loReg <= quo;
          if (bZero) dzFlag <= 1'b1;
        end else begin
          hiReg <= prod[2*W-1:W];
          loReg <= prod[W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic [5:0]   startOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         readValid,
  input  logic [5:0]   readFn,
  output logic [W-1:0] readData,
  output logic         stall,
  output logic         busy,
  output logic         done,
  output logic         divZeroFlag
);
  mdStrobe_t    strobe;
  logic [W-1:0] hiReg, loReg;

  md_ctrl #(.ITER(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .strobe(strobe), .busy(busy), .done(done)
  );

  md_path #(.W(W)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .hiReg(hiReg), .loReg(loReg), .dzFlag(divZeroFlag)
  );

  assign stall = readValid && busy;

  always_comb begin
    readData = '0;
    if (readValid && !busy) begin
      if (readFn == RD_HI)      readData = hiReg;
      else if (readFn == RD_LO) readData = loReg;
    end
  end
endmodule

// File: rtl/md_check.sv
module md_check #(
  parameter int W = 32
) (
  input logic       clk,
  input logic       rstN,
  input logic       startValid,
  input logic [5:0] startOp,
  input logic       readValid,
  input logic       stall,
  input logic       busy,
  input logic       done,
  input logic       divZeroFlag
);
  localparam int RW = $clog2(W + 1) + 1;
  logic [RW-1:0] busyRun;
  logic legal;

  assign legal = (startOp >= 6'd24) && (startOp <= 6'd27);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    startValid && !busy && legal |=> busy);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyRun == RW'(W)));
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_stall_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    readValid && busy |-> stall);
  p_no_stall_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stall);
  p_dz_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    divZeroFlag |=> divZeroFlag);
  p_bad_op_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    startValid && !busy && !legal |=> !busy);
endmodule

bind muldiv_unit md_check #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
  .readValid(readValid), .stall(stall), .busy(busy), .done(done),
  .divZeroFlag(divZeroFlag)
);

// File: tb/muldiv_unit_test.sv
module muldiv_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [5:0]  startOp = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        readValid = 1'b0;
  logic [5:0]  readFn = '0;
  logic [31:0] readData;
  logic        stall, busy, done, divZeroFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  muldiv_unit #(.W(32)) uut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startOp(startOp),
    .opA(opA), .opB(opB), .readValid(readValid), .readFn(readFn),
    .readData(readData), .stall(stall), .busy(busy), .done(done),
    .divZeroFlag(divZeroFlag)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      6'd24: return 64'(sa * sb);
      6'd25: return {32'b0, a} * {32'b0, b};
      6'd26: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
      end
      default: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        return {a % b, a / b};
      end
    endcase
  endfunction

  task automatic readHiLo(output logic [31:0] hi, output logic [31:0] lo);
    readValid = 1'b1;
    readFn = 6'd16;
    #1 hi = readData;
    readFn = 6'd18;
    #1 lo = readData;
    readValid = 1'b0;
    @(negedge clk);
  endtask

  // runs one operation, checks schedule and results
  task automatic runOp(input string req, input logic [5:0] op, input logic [31:0] a, input logic [31:0] b);
    int n;
    logic [31:0] hi, lo;
    startValid = 1'b1; startOp = op; opA = a; opB = b;
    @(negedge clk);
    startValid = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk("R1 busy cycles", 64'(n), 64'd32);
    chk("R1 done pulse", {63'b0, done}, 64'd1);
    @(negedge clk);
    readValid = 1'b1; readFn = 6'd16;
    #1 chk("R7 no stall when idle", {63'b0, stall}, 64'd0);
    readValid = 1'b0;
    readHiLo(hi, lo);
    chk(req, {hi, lo}, model(op, a, b));
  endtask

  task automatic tReset;
    logic [31:0] hi, lo;
    chk("R11 busy", {63'b0, busy}, 64'd0);
    chk("R11 done", {63'b0, done}, 64'd0);
    chk("R11 dz flag", {63'b0, divZeroFlag}, 64'd0);
    readHiLo(hi, lo);
    chk("R11 hi lo zero", {hi, lo}, 64'd0);
  endtask

  task automatic tBusyStartAndStall;
    int n;
    logic [31:0] hi, lo;
    startValid = 1'b1; startOp = 6'd25; opA = 32'd1000; opB = 32'd3000;
    @(negedge clk);
    startValid = 1'b0;
    n = 0;
    while (busy && n < 100) begin
      n++;
      if (n == 5) begin
        readValid = 1'b1; readFn = 6'd18;
        #1 chk("R8 stall while busy", {63'b0, stall}, 64'd1);
        readValid = 1'b0;
      end
      if (n == 10) begin
        startValid = 1'b1; startOp = 6'd27; opA = 32'd77; opB = 32'd5;
      end
      @(negedge clk);
      startValid = 1'b0;
    end
    chk("R9 original schedule kept", 64'(n), 64'd32);
    @(negedge clk);
    readHiLo(hi, lo);
    chk("R9 original result kept", {hi, lo}, 64'd3000000);
  endtask

  task automatic tIllegal;
    logic [31:0] hi, lo, hi0, lo0;
    readHiLo(hi0, lo0);
    startValid = 1'b1; startOp = 6'd28; opA = 32'd9; opB = 32'd9;
    @(negedge clk);
    startValid = 1'b0;
    chk("R10 busy stays low", {63'b0, busy}, 64'd0);
    @(negedge clk);
    readHiLo(hi, lo);
    chk("R10 hi lo unchanged", {hi, lo}, {hi0, lo0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    runOp("R2 multu max", 6'd25, 32'hFFFFFFFF, 32'hFFFFFFFF);
    runOp("R2 multu mixed", 6'd25, 32'd12345, 32'd6789);
    runOp("R3 mult neg x pos", 6'd24, 32'hFFFFFFFD, 32'd7);
    runOp("R3 mult min x min", 6'd24, 32'h80000000, 32'h80000000);
    runOp("R4 divu small", 6'd27, 32'd100, 32'd7);
    runOp("R4 divu by one", 6'd27, 32'hFFFFFFFF, 32'd1);
    runOp("R5 div neg dividend", 6'd26, 32'hFFFFFFF9, 32'd2);
    runOp("R5 div neg divisor", 6'd26, 32'd7, 32'hFFFFFFFE);
    runOp("R5 div min by minus one", 6'd26, 32'h80000000, 32'hFFFFFFFF);
    chk("R6 flag low before zero divide", {63'b0, divZeroFlag}, 64'd0);
    runOp("R6 divu by zero", 6'd27, 32'd5, 32'd0);
    chk("R6 flag set", {63'b0, divZeroFlag}, 64'd1);
    runOp("R6 div neg by zero", 6'd26, 32'hFFFFFFF7, 32'd0);
    runOp("R3 mult after zero divide", 6'd24, 32'd6, 32'hFFFFFFFF);
    chk("R6 flag sticky", {63'b0, divZeroFlag}, 64'd1);
    tBusyStartAndStall();
    tIllegal();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule